// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the test access port of a synchronous memory device, following IEEE 1149.1. A tester drives a test clock, a mode-select line and serial data. The block steps a sixteen-state controller and shifts bits through one of four registers: a 3-bit instruction register, a 32-bit identification register, a one-bit bypass register or a boundary register. The boundary register has one bit per memory pin position.

The memory side sees three things. The first is the captured pin values. The second is a set of latched boundary values that the pad logic drives out when told to. The third is two controls: one selects the boundary values for the output drivers, and one forces every memory output to high impedance. The block never gates the memory's inputs, so the array keeps following its pins in every instruction, including the external-test one.

Some positions of the boundary register have no pin. On capture, those positions take fixed default bits set by parameters.

Top module: `bscan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset and the instruction is IDCODE. In that state `tdo_en`, `out_sel`, `out_hiz` and every bit of `bs_out` are 0.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. Entering that state restores IDCODE as the active instruction.
- R3: Capture-IR loads the pattern `001` into the instruction shift register. The bits leave on `tdo` least significant first: 1, 0, 0.
- R4: A shifted instruction becomes active only at the falling edge of `tck` in Update-IR. Until that edge, and through Shift-IR and Exit1-IR, the outputs keep the old instruction's controls.
- R5: Instruction `001` (IDCODE) places the 32-bit identification register between `tdi` and `tdo`. Capture-DR loads it with `ID_VALUE`, default `32'h1A5C_E0B3`, which is shifted out least significant bit first.
- R6: Instruction `111` (BYPASS) places a one-bit register in the path. Capture-DR clears it, so the first bit out is 0 and each later bit is `tdi` delayed by one clock. The unused codes `011`, `101` and `110` behave the same way.
- R7: Instruction `100` (sample/preload) places the boundary register in the path, and its Capture-DR loads it in parallel. Bit i becomes `pin_in[i]` where `PIN_MASK[i]` is 1, and `BSR_DEFAULT[i]` otherwise. The defaults are `16'h3FFF` for the mask and `16'h8000` for the default bits. Under this instruction `out_sel` and `out_hiz` stay 0.
- R8: Instruction `000` (EXTEST) raises `out_sel`, so each output driver takes its `bs_out` bit. A pattern preloaded earlier appears on `bs_out` unchanged.
- R9: Under EXTEST, Capture-DR loads the boundary register from the pins and defaults in the same way as R7.
- R10: Instruction `010` (SAMPLE-Z) raises `out_hiz` and keeps `out_sel` low, with the boundary register in the scan path. `out_sel` and `out_hiz` are never high together.
- R11: `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. `tdo_en` and `tdo` change on the falling edge of `tck`.
- R12: `bs_out` takes the boundary shift register's contents only at the falling edge of `tck` in Update-DR, and only under an instruction that selects the boundary register. A data scan under BYPASS leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid while `tdo_en` is high |
| tdo_en | output | 1 | Output enable for the `tdo` pad |
| pin_in | input | BSR_LEN | Present state of the memory's pins, per boundary position |
| bs_out | output | BSR_LEN | Latched boundary values for the output drivers |
| out_sel | output | 1 | Output drivers take `bs_out` instead of the memory's data |
| out_hiz | output | 1 | Force all memory outputs to high impedance |

## Verification
Each result has a fixed due time:
- A register captured in a Capture state gives its first bit on `tdo` at the falling edge that follows entry into the Shift state.
- Each later bit follows one `tck` period after the one before it.
- `out_sel` and `out_hiz` move at the falling edge inside Update-IR.
- `bs_out` moves at the falling edge inside Update-DR.

The bench changes `tms` and `tdi` one time unit after a falling edge, and reads `tdo` at that same point, before the rising edge that shifts. Controls are checked one time unit after the relevant falling edge. For R4 and R11 they are also checked one time unit after the preceding rising edge, to show that nothing moved early.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0,
    ST_RTI    = 4'h1,
    ST_SEL_DR = 4'h2,
    ST_CAP_DR = 4'h3,
    ST_SH_DR  = 4'h4,
    ST_EX1_DR = 4'h5,
    ST_PAU_DR = 4'h6,
    ST_EX2_DR = 4'h7,
    ST_UPD_DR = 4'h8,
    ST_SEL_IR = 4'h9,
    ST_CAP_IR = 4'hA,
    ST_SH_IR  = 4'hB,
    ST_EX1_IR = 4'hC,
    ST_PAU_IR = 4'hD,
    ST_EX2_IR = 4'hE,
    ST_UPD_IR = 4'hF
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     drive_out;
    logic     force_hiz;
  } ir_dec_t;

  function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d.path      = PATH_BYP;
    d.drive_out = 1'b0;
    d.force_hiz = 1'b0;
    case (op)
      OP_EXTEST: begin d.path = PATH_BSR; d.drive_out = 1'b1; end
      OP_IDCODE: d.path = PATH_ID;
      OP_SAMPLE: d.path = PATH_BSR;
      OP_SAMPZ:  begin d.path = PATH_BSR; d.force_hiz = 1'b1; end
      default:   d.path = PATH_BYP;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_TLR:    state_nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   state_nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= state_nxt;
  end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] ir_active
);

  logic [IR_W-1:0] ir_sh, ir_sh_nxt;
  logic            ir_sh_en;
  logic [IR_W-1:0] ir_act_nxt;
  logic            ir_act_en;

  always_comb begin
    ir_sh_en  = 1'b0;
    ir_sh_nxt = ir_sh;
    if (state == ST_CAP_IR) begin
      ir_sh_en  = 1'b1;
      ir_sh_nxt = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      ir_sh_en  = 1'b1;
      ir_sh_nxt = {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ir_sh <= IR_CAPTURE;
    else if (ir_sh_en) ir_sh <= ir_sh_nxt;
  end

  always_comb begin
    ir_act_en  = 1'b0;
    ir_act_nxt = ir_active;
    if (state == ST_TLR) begin
      ir_act_en  = 1'b1;
      ir_act_nxt = OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_act_en  = 1'b1;
      ir_act_nxt = ir_sh;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)        ir_active <= OP_IDCODE;
    else if (ir_act_en) ir_active <= ir_act_nxt;
  end

  assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
  import bscan_pkg::*;
#(
  parameter int                 BSR_LEN     = 16,
  parameter logic [BSR_LEN-1:0] PIN_MASK    = 16'h3FFF,
  parameter logic [BSR_LEN-1:0] BSR_DEFAULT = 16'h8000,
  parameter logic [31:0]        ID_VALUE    = 32'h1A5C_E0B3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  input  dr_path_e           path,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bs_out
);

  localparam int ID_W = 32;

  logic               cap, sh;
  logic               byp_q, byp_nxt, byp_en;
  logic [ID_W-1:0]    id_q, id_nxt;
  logic               id_en;
  logic [BSR_LEN-1:0] bsr_q, bsr_nxt, bsr_cap;
  logic               bsr_en;
  logic               upd_en;

  assign cap = (state == ST_CAP_DR);
  assign sh  = (state == ST_SH_DR);

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cap
    if (PIN_MASK[i]) begin : g_pin
      assign bsr_cap[i] = pin_in[i];
    end else begin : g_fixed
      assign bsr_cap[i] = BSR_DEFAULT[i];
    end
  end

  always_comb begin
    byp_en  = (path == PATH_BYP) && (cap || sh);
    byp_nxt = cap ? 1'b0 : tdi;
    id_en   = (path == PATH_ID) && (cap || sh);
    id_nxt  = cap ? ID_VALUE : {tdi, id_q[ID_W-1:1]};
    bsr_en  = (path == PATH_BSR) && (cap || sh);
    bsr_nxt = cap ? bsr_cap : {tdi, bsr_q[BSR_LEN-1:1]};
    upd_en  = (path == PATH_BSR) && (state == ST_UPD_DR);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_nxt;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    id_q <= ID_VALUE;
    else if (id_en) id_q <= id_nxt;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     bsr_q <= '0;
    else if (bsr_en) bsr_q <= bsr_nxt;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     bs_out <= '0;
    else if (upd_en) bs_out <= bsr_q;
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_q[0];
      PATH_BSR: dr_lsb = bsr_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int                 BSR_LEN     = 16,
  parameter logic [BSR_LEN-1:0] PIN_MASK    = 16'h3FFF,
  parameter logic [BSR_LEN-1:0] BSR_DEFAULT = 16'h8000,
  parameter logic [31:0]        ID_VALUE    = 32'h1A5C_E0B3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bs_out,
  output logic               out_sel,
  output logic               out_hiz
);

  tap_state_e      state;
  logic            ir_lsb, dr_lsb;
  logic [IR_W-1:0] ir_active;
  ir_dec_t         dec;
  logic            tdo_nxt, tdo_en_nxt;

  bscan_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  bscan_ir u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state),
    .tdi       (tdi),
    .ir_lsb    (ir_lsb),
    .ir_active (ir_active)
  );

  assign dec = decode_op(ir_active);

  bscan_dr #(
    .BSR_LEN     (BSR_LEN),
    .PIN_MASK    (PIN_MASK),
    .BSR_DEFAULT (BSR_DEFAULT),
    .ID_VALUE    (ID_VALUE)
  ) u_dr (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .path   (dec.path),
    .pin_in (pin_in),
    .dr_lsb (dr_lsb),
    .bs_out (bs_out)
  );

  always_comb begin
    tdo_en_nxt = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_nxt    = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= tdo_en_nxt;
    end
  end

  assign out_sel = dec.drive_out;
  assign out_hiz = dec.force_hiz;

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_pkg::*;
#(
  parameter int BSR_LEN = 16
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_active,
  input logic               tdo_en,
  input logic               out_sel,
  input logic               out_hiz,
  input logic [BSR_LEN-1:0] bs_out
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    hi_cnt <= '0;
    else if (!tms)  hi_cnt <= '0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == ST_TLR));

  a_r1_tlr_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (ir_active == OP_IDCODE));

  a_r4_ir_only_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |-> $stable(ir_active));

  a_r11_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  a_r10_sel_hiz_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    !(out_sel && out_hiz));

  a_r12_update_only_in_upd_dr: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_DR) |-> $stable(bs_out));

endmodule

bind bscan_tap bscan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tms       (tms),
  .state     (state),
  .ir_active (ir_active),
  .tdo_en    (tdo_en),
  .out_sel   (out_sel),
  .out_hiz   (out_hiz),
  .bs_out    (bs_out)
);

// File: tb/bscan_tap_tb.sv
module bscan_tap_tb;

  localparam int          L    = 16;
  localparam logic [L-1:0] MASK = 16'h3FFF;
  localparam logic [L-1:0] DEF  = 16'h8000;
  localparam logic [31:0]  IDV  = 32'h1A5C_E0B3;

  logic         tck = 1'b0;
  logic         trst_n, tms, tdi;
  logic         tdo, tdo_en, out_sel, out_hiz;
  logic [L-1:0] pin_in, bs_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 tck = ~tck;

  bscan_tap u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .pin_in(pin_in), .bs_out(bs_out),
    .out_sel(out_sel), .out_hiz(out_hiz)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] cap_of(input logic [L-1:0] p);
    return (p & MASK) | (DEF & ~MASK);
  endfunction

  task automatic tick(input logic m, input logic d, output logic o);
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic tlr_reset();
    logic o;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap);
    logic o;
    tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i], o);
      cap[i] = o;
    end
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 tdo_en", {63'd0, tdo_en}, 64'd0);
    chk("R1 out_sel", {63'd0, out_sel}, 64'd0);
    chk("R1 out_hiz", {63'd0, out_hiz}, 64'd0);
    chk("R1 bs_out", {48'd0, bs_out}, 64'd0);
    tick(1'b0, 1'b0, d[0]);
    scan_dr(32, 64'd0, d);
    chk("R5 idcode after reset", d, {32'd0, IDV});
  endtask

  task automatic t_ir_capture();
    logic [2:0] c;
    scan_ir(3'b001, c);
    chk("R3 IR capture pattern", {61'd0, c}, 64'd1);
  endtask

  task automatic t_ir_update_timing();
    logic o;
    tick(1'b1, 1'b0, o); tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o); tick(1'b0, 1'b0, o);
    chk("R11 tdo_en in Shift-IR", {63'd0, tdo_en}, 64'd1);
    for (int i = 0; i < 3; i++) tick(i == 2, 1'b0, o);
    chk("R4 out_sel in Exit1-IR", {63'd0, out_sel}, 64'd0);
    tms = 1'b1;
    @(posedge tck); #1;
    chk("R4 out_sel before falling edge", {63'd0, out_sel}, 64'd0);
    @(negedge tck); #1;
    chk("R4 out_sel after Update-IR", {63'd0, out_sel}, 64'd1);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic t_bypass(input logic [2:0] op);
    logic [2:0]  c;
    logic [63:0] d;
    scan_ir(op, c);
    scan_dr(8, 64'hB5, d);
    chk($sformatf("R6 bypass op %0b", op), d, 64'h6A);
  endtask

  task automatic t_sample_preload();
    logic [2:0]  c;
    logic [63:0] d;
    pin_in = 16'h5A3C;
    scan_ir(3'b100, c);
    chk("R7 out_sel under sample", {63'd0, out_sel}, 64'd0);
    chk("R7 out_hiz under sample", {63'd0, out_hiz}, 64'd0);
    scan_dr(L, 64'hC3A5, d);
    chk("R7 sample capture", d, {48'd0, cap_of(16'h5A3C)});
    chk("R12 preload to bs_out", {48'd0, bs_out}, 64'hC3A5);
  endtask

  task automatic t_extest();
    logic [2:0]  c;
    logic [63:0] d;
    scan_ir(3'b000, c);
    chk("R8 out_sel under extest", {63'd0, out_sel}, 64'd1);
    chk("R8 preloaded bs_out", {48'd0, bs_out}, 64'hC3A5);
    pin_in = 16'h0F0F;
    scan_dr(L, 64'h1234, d);
    chk("R9 extest capture", d, {48'd0, cap_of(16'h0F0F)});
    chk("R12 extest update", {48'd0, bs_out}, 64'h1234);
    scan_ir(3'b111, c);
    scan_dr(8, 64'hFF, d);
    chk("R12 bypass leaves bs_out", {48'd0, bs_out}, 64'h1234);
    chk("R8 out_sel dropped", {63'd0, out_sel}, 64'd0);
  endtask

  task automatic t_sampz();
    logic [2:0]  c;
    logic [63:0] d;
    scan_ir(3'b010, c);
    chk("R10 out_hiz", {63'd0, out_hiz}, 64'd1);
    chk("R10 out_sel low", {63'd0, out_sel}, 64'd0);
    pin_in = 16'hFFFF;
    scan_dr(L, 64'd0, d);
    chk("R10 boundary in path", d, {48'd0, cap_of(16'hFFFF)});
  endtask

  task automatic t_tdo_en_timing();
    logic o;
    chk("R11 tdo_en in Run-Test-Idle", {63'd0, tdo_en}, 64'd0);
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
    chk("R11 tdo_en in Capture-DR", {63'd0, tdo_en}, 64'd0);
    tms = 1'b0;
    @(posedge tck); #1;
    chk("R11 tdo_en before falling edge", {63'd0, tdo_en}, 64'd0);
    @(negedge tck); #1;
    chk("R11 tdo_en in Shift-DR", {63'd0, tdo_en}, 64'd1);
    tick(1'b1, 1'b0, o);
    chk("R11 tdo_en in Exit1-DR", {63'd0, tdo_en}, 64'd0);
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
  endtask

  task automatic t_tms_reset();
    logic [2:0]  c;
    logic [63:0] d;
    logic        o;
    scan_ir(3'b000, c);
    tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o); tick(1'b1, 1'b0, o); tick(1'b0, 1'b0, o);
    tlr_reset();
    chk("R2 out_sel cleared", {63'd0, out_sel}, 64'd0);
    scan_dr(32, 64'd0, d);
    chk("R2 idcode restored", d, {32'd0, IDV});
  endtask

  task automatic t_async_reset();
    logic [2:0] c;
    scan_ir(3'b010, c);
    trst_n = 1'b0;
    #2;
    chk("R1 out_hiz under trst_n", {63'd0, out_hiz}, 64'd0);
    chk("R1 bs_out under trst_n", {48'd0, bs_out}, 64'd0);
    @(negedge tck); #1;
    trst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    trst_n = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b0;
    pin_in = '0;
    repeat (3) @(negedge tck);
    #1;
    trst_n = 1'b1;
    t_reset();
    t_ir_capture();
    t_ir_update_timing();
    tlr_reset();
    t_tdo_en_timing();
    t_bypass(3'b111);
    t_bypass(3'b011);
    t_bypass(3'b101);
    t_bypass(3'b110);
    t_sample_preload();
    t_extest();
    t_sampz();
    t_tms_reset();
    t_async_reset();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule